// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block is the processor side of an external bus. An internal requester hands it one transfer at a time: a cycle kind, a word address, active-high byte lanes and write data. The sequencer turns each transfer into an external bus cycle. It drives a word address, active-low byte enables and three status lines that classify the cycle, and it marks each new address with an active-low address strobe. It then waits for the active-low ready input and ends the cycle. Halt and shutdown indications are issued as special cycles with fixed address and lane patterns.

Every cycle takes at least two bus states. Ready is ignored in the first state and sampled in each state after it. If the system asserts the next-address input while the current cycle is still waiting, and the requester already has a transfer waiting, the sequencer accepts it. It then places that transfer's address, lanes and status on the bus, with the strobe, in the following state, while the earlier cycle keeps waiting for its ready. At most one cycle runs ahead in this way. Completion is reported to the requester as a one-clock done pulse, which carries the captured read data.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the strobe is high (idle), the done pulse is low, and the request interface is able to accept.
- R2: The request kind code maps onto the status triple {busMio, busDc, busWr} as follows: 0 interrupt acknowledge gives 000, 1 I/O read gives 010, 2 I/O write gives 011, 3 code read gives 100, 4 memory read gives 110, 5 memory write gives 111, and 6 halt and 7 shutdown both give 101.
- R3: The status triple 001 never appears while the strobe is low.
- R4: A halt cycle drives busAddr (address bits 31..2) to zero with busBeN = 1011, so that only lane 2 is active. A shutdown cycle drives busAddr to zero with busBeN = 1110, so that only lane 0 is active.
- R5: The strobe is low only in the first state of a non-pipelined cycle and in the state that presents a pipelined address. While a cycle waits, the address, byte enables and status stay stable.
- R6: Ready asserted in a cycle's first state has no effect. Each cycle lasts at least two bus states.
- R7: When ready is sampled low, the cycle ends. doneValid pulses high on the next clock. For the read kinds (0, 1, 3, 4), doneData holds busDin as it was in the state where ready was sampled. For the write kinds and the special kinds, doneData is zero.
- R8: When a cycle is waiting with ready high, the next-address input low and a request pending, the request is accepted. In the next state the strobe is low, with the new address, lanes and status on the bus, while the earlier cycle still waits for its ready and completes afterwards.
- R9: A low next-address input with no request pending is ignored: no strobe follows, and the current address stays on the bus.
- R10: reqReady is high only when idle, or when the current cycle waits with no pipelined cycle held and either ready or next-address is low. It is low in a cycle's first state and in the pipelined-address state.
- R11: If ready and next-address are both low while a request is pending, ready takes precedence. The new request starts as a normal non-pipelined cycle with the strobe low in its first state.
- R12: For write kinds (2, 5), busDoutEn is high and busDout carries the write data from the cycle's first state until it ends. busDoutEn is low for read cycles, even while a pipelined write address is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request pending |
| reqReady | output | 1 | Request accepted this clock |
| reqKind | input | 3 | Cycle kind code (see R2) |
| reqAddr | input | ADDR_W-2 | Word address (bits 31..2) |
| reqBen | input | DATA_W/8 | Active-high byte lanes |
| reqWdata | input | DATA_W | Write data |
| busAddr | output | ADDR_W-2 | Bus word address |
| busBeN | output | DATA_W/8 | Active-low byte enables |
| busMio | output | 1 | Status: memory (1) or I/O (0) |
| busDc | output | 1 | Status: data (1) or code/control (0) |
| busWr | output | 1 | Status: write (1) or read (0) |
| busAdsN | output | 1 | Active-low address strobe |
| busReadyN | input | 1 | Active-low cycle ready |
| busNaN | input | 1 | Active-low next-address request |
| busDin | input | DATA_W | Read data from the bus |
| busDout | output | DATA_W | Write data to the bus |
| busDoutEn | output | 1 | Write data drive enable |
| doneValid | output | 1 | One-clock completion pulse |
| doneData | output | DATA_W | Captured read data, or zero |

## Verification
The bench sweeps all eight kinds against zero, one and two wait states, holding ready low through the first state each time. A design that sampled ready too early would end these cycles after one state and report the wrong data. Two pipelined runs send the earlier cycle's ready either in the strobe state or one state later. A sequencer that lost the held cycle, or that let the pipelined write drive the data bus early, would show a missing second done pulse or a wrong busDoutEn. A separate run asserts next-address with no request pending, then asserts ready and next-address together. This catches a strobe raised for a transfer that does not exist and a precedence error that pipelines when it should restart.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    K_INTA = 3'd0,
    K_IORD = 3'd1,
    K_IOWR = 3'd2,
    K_CODE = 3'd3,
    K_MRD  = 3'd4,
    K_MWR  = 3'd5,
    K_HALT = 3'd6,
    K_SHUT = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_T1   = 2'd1,
    S_T2   = 2'd2,
    S_T2P  = 2'd3
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCur;   // latch request into the current-cycle set
    logic loadNxt;   // latch request into the look-ahead set
    logic promote;   // look-ahead set becomes the current set
    logic capture;   // current cycle ends this state
    logic showNxt;   // bus shows the look-ahead address
  } strobe_t;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    busReadyN,
  input  logic    busNaN,
  output logic    busAdsN,
  output logic    doneValid,
  output strobe_t stb,
  output state_e  seqState,
  output logic    pipeHeld
);

  state_e nextState;
  logic   nextPipe;
  logic   endNow;

  always_comb begin
    nextState = seqState;
    nextPipe  = pipeHeld;
    reqReady  = 1'b0;
    endNow    = 1'b0;
    stb       = '0;
    unique case (seqState)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.loadCur = 1'b1;
          nextState   = S_T1;
        end
      end
      S_T1: begin
        // ready is not looked at in a first state
        nextState = S_T2;
      end
      S_T2: begin
        if (!busReadyN) begin
          endNow = 1'b1;
          if (pipeHeld) begin
            stb.promote = 1'b1;
            nextPipe    = 1'b0;
            nextState   = S_T2;
          end else begin
            reqReady = 1'b1;
            if (reqValid) begin
              stb.loadCur = 1'b1;
              nextState   = S_T1;
            end else begin
              nextState = S_IDLE;
            end
          end
        end else if (!pipeHeld && !busNaN) begin
          reqReady = 1'b1;
          if (reqValid) begin
            stb.loadNxt = 1'b1;
            nextState   = S_T2P;
          end
        end
      end
      S_T2P: begin
        nextState = S_T2;
        if (!busReadyN) begin
          endNow      = 1'b1;
          stb.promote = 1'b1;
        end else begin
          nextPipe = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
    stb.capture = endNow;
    stb.showNxt = (seqState == S_T2P) || pipeHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState  <= S_IDLE;
      pipeHeld  <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      seqState  <= nextState;
      pipeHeld  <= nextPipe;
      doneValid <= endNow;
    end
  end

  assign busAdsN = !((seqState == S_T1) || (seqState == S_T2P));

endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  busy,
  input  logic [2:0]            reqKind,
  input  logic [ADDR_W-3:0]     reqAddr,
  input  logic [DATA_W/8-1:0]   reqBen,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     busDin,
  output logic [ADDR_W-3:0]     busAddr,
  output logic [DATA_W/8-1:0]   busBeN,
  output logic [2:0]            busStat,
  output logic [DATA_W-1:0]     busDout,
  output logic                  busDoutEn,
  output logic [DATA_W-1:0]     doneData
);

  localparam int AW = ADDR_W - 2;
  localparam int BW = DATA_W / 8;
  localparam logic [BW-1:0] HALT_LANE = BW'(4'b0100);
  localparam logic [BW-1:0] SHUT_LANE = BW'(4'b0001);

  typedef struct packed {
    logic [AW-1:0]     addr;
    logic [BW-1:0]     ben;
    logic [2:0]        stat;
    logic              isRead;
    logic              isWrite;
    logic [DATA_W-1:0] wdata;
  } cyc_t;

  cyc_t inCyc, curCyc, nxtCyc;

  always_comb begin
    inCyc.addr    = reqAddr;
    inCyc.ben     = reqBen;
    inCyc.wdata   = reqWdata;
    inCyc.isRead  = 1'b0;
    inCyc.isWrite = 1'b0;
    inCyc.stat    = 3'b000;
    case (kind_e'(reqKind))
      K_INTA: begin inCyc.stat = 3'b000; inCyc.isRead  = 1'b1; end
      K_IORD: begin inCyc.stat = 3'b010; inCyc.isRead  = 1'b1; end
      K_IOWR: begin inCyc.stat = 3'b011; inCyc.isWrite = 1'b1; end
      K_CODE: begin inCyc.stat = 3'b100; inCyc.isRead  = 1'b1; end
      K_MRD:  begin inCyc.stat = 3'b110; inCyc.isRead  = 1'b1; end
      K_MWR:  begin inCyc.stat = 3'b111; inCyc.isWrite = 1'b1; end
      K_HALT: begin
        inCyc.stat  = 3'b101;
        inCyc.addr  = '0;
        inCyc.ben   = HALT_LANE;
        inCyc.wdata = '0;
      end
      default: begin
        inCyc.stat  = 3'b101;
        inCyc.addr  = '0;
        inCyc.ben   = SHUT_LANE;
        inCyc.wdata = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCyc   <= '0;
      nxtCyc   <= '0;
      doneData <= '0;
    end else begin
      if (stb.capture) begin
        doneData <= curCyc.isRead ? busDin : '0;
      end
      if (stb.loadCur) begin
        curCyc <= inCyc;
      end else if (stb.promote) begin
        curCyc <= nxtCyc;
      end
      if (stb.loadNxt) begin
        nxtCyc <= inCyc;
      end
    end
  end

  always_comb begin
    if (stb.showNxt) begin
      busAddr = nxtCyc.addr;
      busBeN  = ~nxtCyc.ben;
      busStat = nxtCyc.stat;
    end else begin
      busAddr = curCyc.addr;
      busBeN  = ~curCyc.ben;
      busStat = curCyc.stat;
    end
  end

  assign busDout   = curCyc.wdata;
  assign busDoutEn = busy && curCyc.isWrite;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [2:0]            reqKind,
  input  logic [ADDR_W-3:0]     reqAddr,
  input  logic [DATA_W/8-1:0]   reqBen,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic [ADDR_W-3:0]     busAddr,
  output logic [DATA_W/8-1:0]   busBeN,
  output logic                  busMio,
  output logic                  busDc,
  output logic                  busWr,
  output logic                  busAdsN,
  input  logic                  busReadyN,
  input  logic                  busNaN,
  input  logic [DATA_W-1:0]     busDin,
  output logic [DATA_W-1:0]     busDout,
  output logic                  busDoutEn,
  output logic                  doneValid,
  output logic [DATA_W-1:0]     doneData
);

  strobe_t    stb;
  state_e     seqState;
  logic       pipeHeld;
  logic [2:0] busStat;

  bcs_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .busReadyN (busReadyN),
    .busNaN    (busNaN),
    .busAdsN   (busAdsN),
    .doneValid (doneValid),
    .stb       (stb),
    .seqState  (seqState),
    .pipeHeld  (pipeHeld)
  );

  bcs_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (seqState != S_IDLE),
    .reqKind   (reqKind),
    .reqAddr   (reqAddr),
    .reqBen    (reqBen),
    .reqWdata  (reqWdata),
    .busDin    (busDin),
    .busAddr   (busAddr),
    .busBeN    (busBeN),
    .busStat   (busStat),
    .busDout   (busDout),
    .busDoutEn (busDoutEn),
    .doneData  (doneData)
  );

  assign {busMio, busDc, busWr} = busStat;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int AW = 30,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rstN,
  input state_e        seqState,
  input logic          pipeHeld,
  input logic          reqValid,
  input logic          reqReady,
  input logic [AW-1:0] busAddr,
  input logic [BW-1:0] busBeN,
  input logic          busMio,
  input logic          busDc,
  input logic          busWr,
  input logic          busAdsN,
  input logic          busReadyN,
  input logic          busNaN,
  input logic          doneValid
);

  a_r3_no_reserved_status: assert property (@(posedge clk) disable iff (!rstN)
    !busAdsN |-> ({busMio, busDc, busWr} != 3'b001));

  a_r4_special_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (!busAdsN && {busMio, busDc, busWr} == 3'b101) |->
      (busAddr == '0 && (busBeN == BW'(4'b1011) || busBeN == BW'(4'b1110))));

  a_r5_hold_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == S_T2 && $past(seqState) == S_T2 && $past(busReadyN)) |->
      ($stable(busAddr) && $stable(busBeN) && $stable({busMio, busDc, busWr})));

  a_r6_first_state_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == S_T1) |=> !doneValid);

  a_r8_pipeline_issue: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == S_T2 && !pipeHeld && busReadyN && !busNaN && reqValid) |=>
      (!busAdsN && seqState == S_T2P));

  a_r9_no_phantom_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == S_T2 && busReadyN && !reqValid) |=> busAdsN);

  a_r10_accept_window: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (seqState == S_IDLE || seqState == S_T2));

endmodule

bind bus_cycle_seq bcs_checker #(.AW(ADDR_W - 2), .BW(DATA_W / 8)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .seqState  (seqState),
  .pipeHeld  (pipeHeld),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .busAddr   (busAddr),
  .busBeN    (busBeN),
  .busMio    (busMio),
  .busDc     (busDc),
  .busWr     (busWr),
  .busAdsN   (busAdsN),
  .busReadyN (busReadyN),
  .busNaN    (busNaN),
  .doneValid (doneValid)
);

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqKind = '0;
  logic [29:0] reqAddr = '0;
  logic [3:0]  reqBen = '0;
  logic [31:0] reqWdata = '0;
  logic [29:0] busAddr;
  logic [3:0]  busBeN;
  logic        busMio, busDc, busWr, busAdsN;
  logic        busReadyN = 1'b1;
  logic        busNaN = 1'b1;
  logic [31:0] busDin = '0;
  logic [31:0] busDout;
  logic        busDoutEn;
  logic        doneValid;
  logic [31:0] doneData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqBen(reqBen), .reqWdata(reqWdata),
    .busAddr(busAddr), .busBeN(busBeN), .busMio(busMio), .busDc(busDc),
    .busWr(busWr), .busAdsN(busAdsN), .busReadyN(busReadyN), .busNaN(busNaN),
    .busDin(busDin), .busDout(busDout), .busDoutEn(busDoutEn),
    .doneValid(doneValid), .doneData(doneData)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [2:0] expStat(input logic [2:0] k);
    case (k)
      3'd0: return 3'b000;
      3'd1: return 3'b010;
      3'd2: return 3'b011;
      3'd3: return 3'b100;
      3'd4: return 3'b110;
      3'd5: return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic isRd(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd3) || (k == 3'd4);
  endfunction

  function automatic logic isWr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd5);
  endfunction

  function automatic logic [29:0] expAddr(input logic [2:0] k, input logic [29:0] a);
    return (k >= 3'd6) ? 30'd0 : a;
  endfunction

  function automatic logic [3:0] expBeN(input logic [2:0] k, input logic [3:0] b);
    if (k == 3'd6) return 4'b1011;
    if (k == 3'd7) return 4'b1110;
    return ~b;
  endfunction

  task automatic drive_req(input logic [2:0] k, input logic [29:0] a,
                           input logic [3:0] b, input logic [31:0] w);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqBen = b; reqWdata = w;
  endtask

  task automatic run_simple(input logic [2:0] k, input int waits);
    logic [29:0] a;
    logic [3:0]  b;
    logic [31:0] w, d;
    a = 30'h0400_0000 | (30'(k) << 8) | 30'(waits);
    b = 4'(k + 3'(waits) + 3'd1) | 4'b0001;
    w = 32'hA500_0000 | (32'(k) << 8) | 32'(waits);
    d = 32'h5A00_0000 | (32'(k) << 4) | 32'(waits);
    drive_req(k, a, b, w);
    #1;
    chk("R10 accept in idle", reqReady, 1'b1);
    step;
    chk("R5 strobe in first state", busAdsN, 1'b0);
    chk("R2 status triple", {busMio, busDc, busWr}, expStat(k));
    chk("R3 no 001 status", ({busMio, busDc, busWr} == 3'b001), 1'b0);
    chk("R4 address", busAddr, expAddr(k, a));
    chk("R4 byte enables", busBeN, expBeN(k, b));
    chk("R10 no accept in first state", reqReady, 1'b0);
    chk("R12 data enable", busDoutEn, isWr(k));
    if (isWr(k)) chk("R12 write data", busDout, w);
    reqValid = 1'b0;
    busReadyN = 1'b0;
    busDin = ~d;
    step;
    chk("R6 early ready ignored", doneValid, 1'b0);
    chk("R5 strobe released", busAdsN, 1'b1);
    busReadyN = 1'b1;
    for (int i = 0; i < waits; i++) begin
      step;
      chk("R5 address held", busAddr, expAddr(k, a));
      chk("R5 status held", {busMio, busDc, busWr}, expStat(k));
      chk("R6 no done while waiting", doneValid, 1'b0);
      if (isWr(k)) chk("R12 write data held", busDout, w);
    end
    busReadyN = 1'b0;
    busDin = d;
    step;
    chk("R7 done pulse", doneValid, 1'b1);
    chk("R7 done data", doneData, isRd(k) ? d : 32'd0);
    chk("R5 idle strobe high", busAdsN, 1'b1);
    busReadyN = 1'b1;
    busDin = '0;
    step;
    chk("R7 done is one clock", doneValid, 1'b0);
  endtask

  task automatic run_pipe(input logic readyInLookAhead);
    logic [29:0] aA, aB;
    logic [31:0] wB, dA;
    aA = 30'h0200_0010;
    aB = 30'h0300_0020;
    wB = 32'hCAFE_0001;
    dA = 32'h1234_5678 ^ {31'd0, readyInLookAhead};
    drive_req(3'd4, aA, 4'hF, 32'd0);
    step;
    reqValid = 1'b0;
    step;
    busNaN = 1'b0;
    drive_req(3'd5, aB, 4'b0011, wB);
    #1;
    chk("R8 accept on next-address", reqReady, 1'b1);
    step;
    chk("R8 look-ahead strobe", busAdsN, 1'b0);
    chk("R8 look-ahead address", busAddr, aB);
    chk("R8 look-ahead status", {busMio, busDc, busWr}, 3'b111);
    chk("R8 look-ahead lanes", busBeN, 4'b1100);
    chk("R8 earlier cycle not done", doneValid, 1'b0);
    chk("R10 no accept in look-ahead state", reqReady, 1'b0);
    chk("R12 read keeps data bus off", busDoutEn, 1'b0);
    reqValid = 1'b0;
    busNaN = 1'b1;
    if (!readyInLookAhead) begin
      step;
      chk("R8 strobe released while held", busAdsN, 1'b1);
      chk("R8 held address stays", busAddr, aB);
      chk("R8 still waiting", doneValid, 1'b0);
      chk("R12 held write not driven", busDoutEn, 1'b0);
    end
    busReadyN = 1'b0;
    busDin = dA;
    step;
    chk("R8 earlier cycle done", doneValid, 1'b1);
    chk("R7 earlier read data", doneData, dA);
    chk("R8 no second strobe", busAdsN, 1'b1);
    chk("R12 write now driven", busDoutEn, 1'b1);
    chk("R12 write data", busDout, wB);
    busDin = '0;
    step;
    chk("R8 pipelined write done", doneValid, 1'b1);
    chk("R7 write reports zero", doneData, 32'd0);
    busReadyN = 1'b1;
    step;
    chk("R1 back to idle", reqReady, 1'b1);
  endtask

  task automatic run_na_cases;
    logic [29:0] aA, aB;
    logic [31:0] dA, dB;
    aA = 30'h0011_2233;
    aB = 30'h0022_3344;
    dA = 32'hDEAD_0001;
    dB = 32'hBEEF_0002;
    drive_req(3'd1, aA, 4'b0001, 32'd0);
    step;
    reqValid = 1'b0;
    step;
    busNaN = 1'b0;
    step;
    chk("R9 next-address alone gives no strobe", busAdsN, 1'b1);
    chk("R9 address unchanged", busAddr, aA);
    chk("R9 still waiting", doneValid, 1'b0);
    drive_req(3'd3, aB, 4'hF, 32'd0);
    busReadyN = 1'b0;
    busDin = dA;
    #1;
    chk("R10 accept at end of cycle", reqReady, 1'b1);
    step;
    chk("R11 ready wins, first-state strobe", busAdsN, 1'b0);
    chk("R11 new address", busAddr, aB);
    chk("R11 code read status", {busMio, busDc, busWr}, 3'b100);
    chk("R7 I/O read done", doneValid, 1'b1);
    chk("R7 I/O read data", doneData, dA);
    reqValid = 1'b0;
    busNaN = 1'b1;
    busDin = dB;
    step;
    chk("R6 ready in first state ignored", doneValid, 1'b0);
    step;
    chk("R7 code read done", doneValid, 1'b1);
    chk("R7 code read data", doneData, dB);
    busReadyN = 1'b1;
    busDin = '0;
    step;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary;
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    chk("R1 strobe high after reset", busAdsN, 1'b1);
    chk("R1 no done after reset", doneValid, 1'b0);
    chk("R1 ready to accept", reqReady, 1'b1);
    step;
    for (int k = 0; k < 8; k++) begin
      for (int w = 0; w < 3; w++) begin
        run_simple(3'(k), w);
      end
    end
    run_pipe(1'b1);
    run_pipe(1'b0);
    run_na_cases;
    summary;
    $finish;
  end

endmodule